// File: doc/BRIEF.md
# Port Auto-Partition Controller

This block watches one repeater port and cuts it off from the repeater core when the port misbehaves on the shared medium. It takes the port's receive-activity flag, its collision flag and a one-cycle bit-time tick. When the port piles up too many collisions in a row, or holds a single collision for too long, the block marks the port partitioned. While a port is partitioned its data and collision flags, as passed on to the core, are forced to idle. The port gets back in only after it carries one long transmission with no collision in it. A repeater uses one instance per port: four twisted-pair ports and one attachment-unit port.

Each instance runs an eight-state machine in two halves. In the connected half, IDLE goes to WATCH when activity starts. WATCH goes to CC_INC when a collision appears, to CC_CLEAR when the watch window runs out with no collision, and back to IDLE on quiet. CC_INC adds one to the count on entry. It goes to P_WAIT when the count has reached its limit, or when a collision is still present after the long-collision window, and to IDLE on quiet. CC_CLEAR zeroes the count on entry. It goes to CC_INC on a collision and to IDLE on quiet.

In the partitioned half, P_WAIT goes to P_HOLD on quiet. P_HOLD goes to P_CWATCH when activity starts. P_CWATCH goes back to P_WAIT on a collision, to P_HOLD on quiet, and to P_RESTORE when the watch window runs out cleanly. P_RESTORE zeroes the count on entry and goes to IDLE on quiet. A single bit-time timer restarts on every state change.

Top module: `port_isolator`

## Requirements
- R1: While reset is held, and right after it, partitioned is 0, coll_count is 0 and the gated outputs follow the port inputs.
- R2: While the port is not partitioned, data_out equals data_present and coll_out equals coll_present in the same cycle.
- R3: Each activity burst that shows a collision while the port is connected raises coll_count by exactly one. coll_count never goes above CC_LIMIT (64) and never wraps.
- R4: Collision-free activity that lasts WATCH_BITS (500) bit ticks returns coll_count to 0. Collision-free activity of well under WATCH_BITS ticks leaves coll_count unchanged.
- R5: partitioned rises on the clock edge after coll_count reaches CC_LIMIT. With CC_LIMIT-1 counted collisions the port is still connected.
- R6: A collision held for LONG_BITS (1000) bit ticks after it was counted partitions the port, whatever the count. One that ends roughly ten ticks sooner does not.
- R7: While partitioned, data_out and coll_out are 0 and coll_count holds its value.
- R8: A partitioned port comes back (partitioned 0, coll_count 0) after quiet, then WATCH_BITS bit ticks of activity with no collision, then quiet. A collision inside that window keeps the port partitioned.
- R9: The watch and long-collision timers advance only in cycles where bit_tick is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per bit time; advances the timers |
| data_present | input | 1 | Receive activity seen on the port |
| coll_present | input | 1 | Collision seen on the port |
| data_out | output | 1 | Activity passed to the repeater core, forced to 0 while partitioned |
| coll_out | output | 1 | Collision passed to the repeater core, forced to 0 while partitioned |
| partitioned | output | 1 | 1 while the port is isolated |
| coll_count | output | $clog2(CC_LIMIT+1) | Consecutive-collision count |

## Verification
The assertions assume the port flags are synchronous to clk and stay stable from one clock to the next. They also assume a collision is always reported together with activity, or at least counts as activity. The stimulus changes inputs only on falling edges. It shapes traffic into bursts that are always followed by at least four quiet cycles, so every burst starts from a settled state. Clean long bursts run a few ticks past the watch window, and the long-collision cases sit about ten ticks on each side of the limit, so the checks do not hinge on the exact entry cycle.

// File: rtl/port_isolator_pkg.sv
package port_isolator_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WATCH,
        S_CC_INC,
        S_CC_CLEAR,
        S_P_WAIT,
        S_P_HOLD,
        S_P_CWATCH,
        S_P_RESTORE
    } pi_state_e;

endpackage

// File: rtl/pi_bit_timer.sv
module pi_bit_timer #(
    parameter int WATCH_BITS = 500,
    parameter int LONG_BITS  = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bit_tick,
    output logic watch_done,
    output logic long_done
);
    localparam int MAXV = (LONG_BITS > WATCH_BITS) ? LONG_BITS : WATCH_BITS;
    localparam int TW   = $clog2(MAXV + 1);
    localparam logic [TW-1:0] MAX_V   = TW'(MAXV);
    localparam logic [TW-1:0] WATCH_V = TW'(WATCH_BITS);
    localparam logic [TW-1:0] LONG_V  = TW'(LONG_BITS);

    logic [TW-1:0] elapsed;

    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (restart)
            elapsed <= '0;
        else if (bit_tick && (elapsed < MAX_V))
            elapsed <= elapsed + 1'b1;
    end

    assign watch_done = (elapsed >= WATCH_V);
    assign long_done  = (elapsed >= LONG_V);

    // R9: without a tick or a restart the elapsed time does not move
    assert_timer_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && !restart) |=> $stable(elapsed));

endmodule

// File: rtl/pi_coll_counter.sv
module pi_coll_counter #(
    parameter int CC_LIMIT = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          inc,
    input  logic                          clr,
    output logic [$clog2(CC_LIMIT+1)-1:0] count,
    output logic                          at_limit
);
    localparam int CW = $clog2(CC_LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(CC_LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count < LIM_V))
            count <= count + 1'b1;
    end

    assign at_limit = (count >= LIM_V);

    // R3: saturated count stays put unless explicitly cleared
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(count) == LIM_V && !$past(clr)) |-> (count == LIM_V));

    // R3: a single step at most per clock
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/pi_fsm.sv
module pi_fsm
    import port_isolator_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_present,
    input  logic coll_present,
    input  logic watch_done,
    input  logic long_done,
    input  logic at_limit,
    output logic partitioned,
    output logic cnt_inc,
    output logic cnt_clr,
    output logic tmr_restart
);
    pi_state_e state, nxt;
    logic act;

    assign act = data_present | coll_present;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (act) nxt = S_WATCH;
            S_WATCH: begin
                if (coll_present)    nxt = S_CC_INC;
                else if (!act)       nxt = S_IDLE;
                else if (watch_done) nxt = S_CC_CLEAR;
            end
            S_CC_INC: begin
                if (at_limit || (long_done && coll_present)) nxt = S_P_WAIT;
                else if (!act)                               nxt = S_IDLE;
            end
            S_CC_CLEAR: begin
                if (coll_present) nxt = S_CC_INC;
                else if (!act)    nxt = S_IDLE;
            end
            S_P_WAIT:    if (!act) nxt = S_P_HOLD;
            S_P_HOLD:    if (act)  nxt = S_P_CWATCH;
            S_P_CWATCH: begin
                if (coll_present)    nxt = S_P_WAIT;
                else if (!act)       nxt = S_P_HOLD;
                else if (watch_done) nxt = S_P_RESTORE;
            end
            S_P_RESTORE: if (!act) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    always_comb begin
        partitioned = (state == S_P_WAIT) || (state == S_P_HOLD) ||
                      (state == S_P_CWATCH) || (state == S_P_RESTORE);
        cnt_inc     = (nxt == S_CC_INC) && (state != S_CC_INC);
        cnt_clr     = ((nxt == S_CC_CLEAR) && (state != S_CC_CLEAR)) ||
                      ((nxt == S_P_RESTORE) && (state != S_P_RESTORE));
        tmr_restart = (nxt != state);
    end

    // R5/R6: isolation only follows a full count or an over-long collision
    assert_part_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(partitioned) |-> ($past(at_limit) || ($past(long_done) && $past(coll_present))));

    // R8: leaving isolation only happens once the port has gone quiet
    assert_restore_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(partitioned) |-> ($past(!data_present) && $past(!coll_present)));

endmodule

// File: rtl/port_isolator.sv
module port_isolator #(
    parameter int CC_LIMIT   = 64,
    parameter int WATCH_BITS = 500,
    parameter int LONG_BITS  = 1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_tick,
    input  logic                          data_present,
    input  logic                          coll_present,
    output logic                          data_out,
    output logic                          coll_out,
    output logic                          partitioned,
    output logic [$clog2(CC_LIMIT+1)-1:0] coll_count
);
    logic watch_done, long_done, at_limit;
    logic cnt_inc, cnt_clr, tmr_restart;

    pi_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_present (data_present),
        .coll_present (coll_present),
        .watch_done   (watch_done),
        .long_done    (long_done),
        .at_limit     (at_limit),
        .partitioned  (partitioned),
        .cnt_inc      (cnt_inc),
        .cnt_clr      (cnt_clr),
        .tmr_restart  (tmr_restart)
    );

    pi_bit_timer #(
        .WATCH_BITS (WATCH_BITS),
        .LONG_BITS  (LONG_BITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (tmr_restart),
        .bit_tick   (bit_tick),
        .watch_done (watch_done),
        .long_done  (long_done)
    );

    pi_coll_counter #(
        .CC_LIMIT (CC_LIMIT)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_inc),
        .clr      (cnt_clr),
        .count    (coll_count),
        .at_limit (at_limit)
    );

    assign data_out = data_present & ~partitioned;
    assign coll_out = coll_present & ~partitioned;

    // R7: the count is frozen across consecutive isolated cycles unless restored to zero
    assert_frozen_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (partitioned && $past(partitioned) && coll_count != '0) |-> $stable(coll_count));

    // R8: a reconnected port starts from a zero count
    assert_restore_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(partitioned) |-> (coll_count == '0));

endmodule

// File: tb/port_isolator_tb_top.sv
module port_isolator_tb_top;
    localparam int LIMIT = 64;
    localparam int WATCH = 500;
    localparam int LONG  = 1000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, bit_tick, data_present, coll_present;
    logic data_out, coll_out, partitioned;
    logic [6:0] coll_count;

    port_isolator #(.CC_LIMIT(LIMIT), .WATCH_BITS(WATCH), .LONG_BITS(LONG)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .data_present(data_present), .coll_present(coll_present),
        .data_out(data_out), .coll_out(coll_out),
        .partitioned(partitioned), .coll_count(coll_count)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    bit exp_part = 1'b0;
    int exp_cnt  = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(bit d, bit c, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            data_present = d;
            coll_present = c;
        end
    endtask

    // episode-level reference: 0 short collision, 1 clean long, 2 clean short
    function automatic void model(int kind);
        if (kind == 0) begin
            if (!exp_part) begin
                if (exp_cnt < LIMIT) exp_cnt++;
                if (exp_cnt == LIMIT) exp_part = 1'b1;
            end
        end else if (kind == 1) begin
            exp_cnt  = 0;
            exp_part = 1'b0;
        end
    endfunction

    task automatic episode(int kind, string req);
        @(negedge clk);
        data_present = 1'b1;
        coll_present = (kind == 0);
        #1;
        chk("R2/R7 data gating", int'(data_out), int'(!exp_part));
        chk("R2/R7 collision gating", int'(coll_out), int'((kind == 0) && !exp_part));
        if (kind == 0)      drive(1'b1, 1'b1, 3);
        else if (kind == 1) drive(1'b1, 1'b0, WATCH + 6);
        else                drive(1'b1, 1'b0, 20);
        drive(1'b0, 1'b0, 4);
        model(kind);
        #1;
        chk({req, " partitioned"}, int'(partitioned), int'(exp_part));
        chk({req, " count"}, int'(coll_count), exp_cnt);
    endtask

    task automatic long_coll(int n, bit expect_part);
        drive(1'b1, 1'b1, n);
        #1;
        chk("R6 long collision partition", int'(partitioned), int'(expect_part));
        if (expect_part) chk("R7 collision gated during isolation", int'(coll_out), 0);
        drive(1'b0, 1'b0, 4);
        exp_cnt++;
        exp_part = expect_part;
        #1;
        chk("R6 count after long collision", int'(coll_count), exp_cnt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bit_tick = 1'b1; data_present = 1'b1; coll_present = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset partitioned", int'(partitioned), 0);
        chk("R1 reset count", int'(coll_count), 0);
        chk("R1 reset data follows", int'(data_out), 1);
        @(negedge clk);
        data_present = 1'b0;
        rst_n = 1'b1;
        drive(1'b0, 1'b0, 3);

        // R3: counted collision bursts
        for (int i = 0; i < 3; i++) episode(0, "R3");
        // R4: short clean burst keeps count, long clean burst clears it
        episode(2, "R4 short");
        episode(1, "R4 long");
        episode(0, "R3 after clear");
        episode(0, "R3");

        // R9: no ticks, long clean burst must not clear
        bit_tick = 1'b0;
        drive(1'b1, 1'b0, WATCH + 6);
        drive(1'b0, 1'b0, 4);
        #1;
        chk("R9 no tick keeps count", int'(coll_count), exp_cnt);
        bit_tick = 1'b1;

        // R6: collision just short of the long window, then past it
        long_coll(LONG - 10, 1'b0);
        long_coll(LONG + 10, 1'b1);

        // R7: collision burst while isolated changes nothing
        episode(0, "R7");
        // R8: collision inside reconnect window keeps isolation
        drive(1'b1, 1'b0, 100);
        drive(1'b1, 1'b1, 3);
        drive(1'b0, 1'b0, 4);
        #1;
        chk("R8 collision in reconnect window", int'(partitioned), 1);
        episode(2, "R8 short clean");
        episode(1, "R8 reconnect");

        // R5: exact limit boundary
        for (int i = 0; i < LIMIT - 1; i++) episode(0, "R5 below limit");
        chk("R5 one below limit", int'(partitioned), 0);
        episode(0, "R5 at limit");
        chk("R5 count saturated", int'(coll_count), LIMIT);
        episode(0, "R3 saturated");
        episode(1, "R8 reconnect after limit");

        // random traffic mix
        for (int i = 0; i < 300; i++) begin
            int r;
            r = $urandom_range(99, 0);
            if (r < 85)      episode(0, "R3 random");
            else if (r < 90) episode(1, "R4 random");
            else             episode(2, "R4 random");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule